// File: doc/BRIEF.md
# Level-Interrupt GPIO Port

This block is a word-wide general-purpose I/O port with an interrupt unit built in. Software reaches it over a simple 32-bit register bus. Each bus access picks one of two register windows and a word slot inside that window. One window controls the pins: direction, output data, interrupt polarity and sticky interrupt status. The other window gives a pending view of the status and a mask register. The block folds every unmasked pending bit into one registered interrupt line for a parent interrupt controller.

Every pin is either an input or a driven output. Inputs pass through a two-stage synchroniser, and the synchronised value feeds both data readback and interrupt detection. Detection is level-sensitive only, and the active level is chosen per pin. While a pin sits at its active level, its status bit is forced to 1 on every cycle. Software clears a status bit by writing a word that has a 0 in that bit, so the clear only lasts once the pin has left its active level.

The bus is a single-cycle strobe. On `bus_en` with `bus_we` high, the word is written at the next clock edge. With `bus_we` low, `bus_rdata` shows the addressed register combinationally. When `bus_en` is low, `bus_rdata` is zero. The word slot `bus_word` is the byte offset divided by four.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset, direction reads 0 and the output enables are all 0. Polarity reads all ones. Mask reads all ones. Pending reads 0 and `irq_out` is 0.
- R2: Pin-window slot 0 (offset 0x00) is direction, and a 1 in a bit makes that pin an output. `pin_oe` equals the direction register and `pin_out` equals the written data register (slot 1, offset 0x04).
- R3: A read of slot 1 returns, bit by bit, the written data where direction is 1 and the synchronised pin level where direction is 0.
- R4: A change on `pin_in` shows up in data readback after exactly two rising clock edges and not after one.
- R5: Pin-window slot 2 (offset 0x08) sets polarity per pin. With a 1 in a bit, that pin's status bit in slot 3 (offset 0x0C) is set while the synchronised pin is high. With a 0, it is set while the pin is low. A status bit stays set after the pin leaves its active level.
- R6: A write to slot 3 clears each status bit whose written bit is 0 and leaves bits written as 1 unchanged. An all-ones write changes nothing.
- R7: A clear written while the pin still sits at its active level has no lasting effect, and the bit reads 1 afterwards.
- R8: Interrupt-window slot 2 (offset 0x08) is the mask, where 1 blocks a pin. `irq_out` is the OR of the status bits ANDed with the inverted mask. It is registered, so it changes one edge after the status or mask register changes.
- R9: Interrupt-window slot 0 (offset 0x00) reads the raw status regardless of mask. Writes to that slot have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = pin window, 1 = interrupt window |
| bus_word | input | 2 | Word slot (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| irq_out | output | 1 | Combined interrupt to the parent controller |

## Verification
The bench looks for an off-by-one in the synchroniser by sampling readback after one edge and after two. A design with one stage too few or too many fails one of those two samples. It issues a status clear while the pin is still active. A design that gave the clear priority over the level would read 0 there. It also clears after the pin has been released and writes an all-ones word. A design that cleared on written ones, or never cleared, shows the wrong status. On the interrupt side, the bench samples `irq_out` one cycle after unmasking and then one cycle later, to catch a combinational or doubly registered output. It writes to the pending slot to catch a design that lets that slot alter the status.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PIN_W   = 32;
  localparam int unsigned WORD_AW = 2;

  typedef enum logic [WORD_AW-1:0] {
    PW_DIR   = 2'd0,
    PW_DATA  = 2'd1,
    PW_POL   = 2'd2,
    PW_STAT  = 2'd3
  } pin_word_e;

  typedef enum logic [WORD_AW-1:0] {
    IW_PEND  = 2'd0,
    IW_MASK  = 2'd2
  } irq_word_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] d;
      if (s == 0) begin : g_first
        assign d = async_in;
      end else begin : g_rest
        assign d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic               bus_win,
  input  logic [WORD_AW-1:0] bus_word,
  input  logic [W-1:0]       bus_wdata,
  output logic [W-1:0]       bus_rdata,
  input  logic [W-1:0]       pin_sync,
  input  logic [W-1:0]       stat,
  output logic [W-1:0]       dir_q,
  output logic [W-1:0]       dout_q,
  output logic [W-1:0]       pol_q,
  output logic [W-1:0]       mask_q,
  output logic               stat_we,
  output logic               dir_we
);
  logic          wr;
  logic          data_we, pol_we, mask_we;
  logic [W-1:0]  dir_d, dout_d, pol_d, mask_d;
  logic [W-1:0]  rd_mux;

  // write decode
  always_comb begin
    wr      = bus_en && bus_we;
    dir_we  = wr && !bus_win && (bus_word == PW_DIR);
    data_we = wr && !bus_win && (bus_word == PW_DATA);
    pol_we  = wr && !bus_win && (bus_word == PW_POL);
    stat_we = wr && !bus_win && (bus_word == PW_STAT);
    mask_we = wr &&  bus_win && (bus_word == IW_MASK);
  end

  // next state with explicit enables
  always_comb begin
    dir_d  = dir_we  ? bus_wdata : dir_q;
    dout_d = data_we ? bus_wdata : dout_q;
    pol_d  = pol_we  ? bus_wdata : pol_q;
    mask_d = mask_we ? bus_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '1;
      mask_q <= '1;
    end else begin
      dir_q  <= dir_d;
      dout_q <= dout_d;
      pol_q  <= pol_d;
      mask_q <= mask_d;
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (!bus_win) begin
      unique case (bus_word)
        PW_DIR:  rd_mux = dir_q;
        PW_DATA: rd_mux = (dir_q & dout_q) | (~dir_q & pin_sync);
        PW_POL:  rd_mux = pol_q;
        PW_STAT: rd_mux = stat;
        default: rd_mux = '0;
      endcase
    end else begin
      case (bus_word)
        IW_PEND: rd_mux = stat;
        IW_MASK: rd_mux = mask_q;
        default: rd_mux = '0;
      endcase
    end
    bus_rdata = (bus_en && !bus_we) ? rd_mux : '0;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] mask,
  input  logic         stat_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat_q,
  output logic         irq_q
);
  logic [W-1:0] active;
  logic [W-1:0] stat_d;
  logic         irq_d;

  always_comb begin
    active = ~(pin_sync ^ pol);
    stat_d = (stat_we ? (stat_q & wdata) : stat_q) | active;
    irq_d  = |(stat_q & ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq
  import gpio_pkg::*;
#(
  parameter int unsigned W           = PIN_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic               bus_win,
  input  logic [WORD_AW-1:0] bus_word,
  input  logic [W-1:0]       bus_wdata,
  output logic [W-1:0]       bus_rdata,
  input  logic [W-1:0]       pin_in,
  output logic [W-1:0]       pin_out,
  output logic [W-1:0]       pin_oe,
  output logic               irq_out
);
  logic         rst_q_n;
  logic [W-1:0] pin_sync;
  logic [W-1:0] dir_q, dout_q, pol_q, mask_q, stat_q;
  logic         stat_we, dir_we;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_regfile #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_q_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_win(bus_win),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_sync(pin_sync), .stat(stat_q),
    .dir_q(dir_q), .dout_q(dout_q), .pol_q(pol_q), .mask_q(mask_q),
    .stat_we(stat_we), .dir_we(dir_we)
  );

  gpio_irq_unit #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_q_n),
    .pin_sync(pin_sync), .pol(pol_q), .mask(mask_q),
    .stat_we(stat_we), .wdata(bus_wdata),
    .stat_q(stat_q), .irq_q(irq_out)
  );

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_lvl_irq_chk.sv
module gpio_lvl_irq_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic [W-1:0] pin_sync,
  input logic [W-1:0] pol_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] stat_q,
  input logic         stat_we,
  input logic         dir_we,
  input logic [W-1:0] pin_oe,
  input logic         irq_out
);
  logic [W-1:0] act_c;
  assign act_c = ~(pin_sync ^ pol_q);

  // R5: an active pin sets its status bit on the next edge
  a_r5_active_sets: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> ((stat_q & $past(act_c)) == $past(act_c)));

  // R6: no status bit falls without a status write
  a_r6_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    !stat_we |=> ((~stat_q & $past(stat_q)) == '0));

  // R8: interrupt output follows unmasked status one edge later
  a_r8_irq_registered: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> (irq_out == $past(|(stat_q & ~mask_q))));

  // R8: fully masked means quiet on the next cycle
  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (&mask_q) |=> !irq_out);

  // R2: output enables only move on a direction write
  a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !dir_we |=> $stable(pin_oe));
endmodule

bind gpio_lvl_irq gpio_lvl_irq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .pin_sync(pin_sync), .pol_q(pol_q),
  .mask_q(mask_q), .stat_q(stat_q), .stat_we(stat_we), .dir_we(dir_we),
  .pin_oe(pin_oe), .irq_out(irq_out)
);

// File: tb/gpio_lvl_irq_tb_top.sv
module gpio_lvl_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we, bus_win;
  logic [1:0]  bus_word;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out, pin_oe;
  logic        irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  gpio_lvl_irq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_win(bus_win), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic win, input logic [1:0] word, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_win = win; bus_word = word; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic win, input logic [1:0] word, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_win = win; bus_word = word;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    pin_in = '0;
    wr(0, 2'd2, 32'hFFFF_FFFF);
    idle(3);
    wr(0, 2'd3, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 2'd0, v); check("R1 dir", v, 32'h0);
    check("R1 oe", pin_oe, 32'h0);
    rd(0, 2'd2, v); check("R1 polarity", v, 32'hFFFF_FFFF);
    rd(1, 2'd2, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(1, 2'd0, v); check("R1 pending", v, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_outputs();
    logic [31:0] v;
    wr(0, 2'd1, 32'hA5A5_F00F);
    wr(0, 2'd0, 32'hFFFF_0000);
    check("R2 oe", pin_oe, 32'hFFFF_0000);
    check("R2 out", pin_out, 32'hA5A5_F00F);
    pin_in = 32'h5A5A_1234;
    idle(3);
    rd(0, 2'd1, v);
    check("R3 mixed readback", v, 32'hA5A5_1234);
    wr(0, 2'd0, 32'h0);
    wr(0, 2'd1, 32'h0);
    check("R2 oe off", pin_oe, 32'h0);
    clear_all();
  endtask

  task automatic t_sync();
    @(negedge clk);
    pin_in = 32'h0000_0080;
    bus_en = 1; bus_we = 0; bus_win = 0; bus_word = 2'd1;
    @(negedge clk); #1;
    check("R4 one edge", bus_rdata, 32'h0);
    @(negedge clk); #1;
    check("R4 two edges", bus_rdata, 32'h0000_0080);
    bus_en = 0;
    clear_all();
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    wr(0, 2'd2, 32'hFFFF_FFFE);   // bit0 active low, others active high
    pin_in = 32'h0000_0021;       // bit0 high (idle), bit5 high (active)
    idle(3);
    wr(0, 2'd3, 32'h0);
    idle(2);
    rd(0, 2'd3, v); check("R5 high active only", v, 32'h0000_0020);
    pin_in = 32'h0000_0020;       // bit0 low -> active
    idle(4);
    rd(0, 2'd3, v); check("R5 low active", v, 32'h0000_0021);
    rd(1, 2'd0, v); check("R9 pending mirrors status", v, 32'h0000_0021);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    pin_in = 32'h0;               // bit5 released, bit0 still active
    idle(4);
    rd(0, 2'd3, v); check("R5 sticky", v, 32'h0000_0021);
    wr(0, 2'd3, 32'hFFFF_FFFF);
    rd(0, 2'd3, v); check("R6 ones keep", v, 32'h0000_0021);
    wr(0, 2'd3, ~32'h0000_0020);
    rd(0, 2'd3, v); check("R6 zero clears", v, 32'h0000_0001);
    wr(0, 2'd3, ~32'h0000_0001);
    rd(0, 2'd3, v); check("R7 clear while active", v, 32'h0000_0001);
    pin_in = 32'h0000_0001;       // bit0 released
    idle(4);
    wr(0, 2'd3, ~32'h0000_0001);
    rd(0, 2'd3, v); check("R6 clear after release", v, 32'h0);
    clear_all();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    pin_in = 32'h0000_0008;
    idle(4);
    rd(1, 2'd0, v); check("R9 pending while masked", v, 32'h0000_0008);
    check("R8 masked irq", {31'b0, irq_out}, 32'h0);
    wr(1, 2'd2, ~32'h0000_0010);
    idle(2);
    check("R8 other bit unmasked", {31'b0, irq_out}, 32'h0);
    wr(1, 2'd2, ~32'h0000_0008);
    check("R8 irq registered", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R8 irq rises", {31'b0, irq_out}, 32'h1);
    pin_in = 32'h0;
    idle(3);
    wr(1, 2'd0, 32'h0);
    rd(1, 2'd0, v); check("R9 pending write ignored", v, 32'h0000_0008);
    wr(1, 2'd2, 32'hFFFF_FFFF);
    idle(1);
    check("R8 remasked", {31'b0, irq_out}, 32'h0);
    wr(0, 2'd3, 32'h0);
  endtask

  initial begin
    bus_en = 0; bus_we = 0; bus_win = 0; bus_word = '0; bus_wdata = '0;
    pin_in = '0;
    rst_n  = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(4);
    t_reset();
    t_outputs();
    t_sync();
    t_polarity();
    t_clear();
    t_mask();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule